// File: doc/BRIEF.md
# Truncating 16-bit floating-point adder

This block adds two numbers held in a compact 16-bit floating-point layout. The top bit is the sign, the next eight bits are an exponent biased by 127, and the low seven bits are the fraction below an implied leading one. An encoding with sign S, exponent E and fraction T stands for (-1)^S × 2^(E−134) × {1, T}, where {1, T} is read as an 8-bit unsigned integer. The all-zero word is the only special value and means positive zero. There is no infinity, no NaN, no subnormal range and no rounding choice. Every bit that falls off during alignment or normalisation is dropped.

All of the arithmetic is one combinational path. It orders the operands by magnitude, shifts the smaller significand right by the exponent gap, adds or subtracts, and renormalises with a leading-one search. A single register holds the result, so a sum appears one clock after its operands are presented. The block can stand as the floating-point add stage of a small processor's execution unit.

Top module: `fpa_add_top`

## Requirements
- R1: The result word uses the layout sign in bit 15, exponent in bits 14:7 (bias 127) and fraction in bits 6:0. For example 1.0 (0x3F80) plus 2.0 (0x4000) gives 3.0 (0x4040).
- R2: The sum appears on `sum_q` exactly one clock edge after the operands are applied. While `rst_n` is low, `sum_q` reads 0x0000.
- R3: Operands of equal sign add, and the result keeps that sign. A carry out of the significand shifts it right by one and raises the exponent by one, so 0x3F80 + 0x3F80 = 0x4000.
- R4: Bits shifted out during alignment are truncated. 10.0 (0x4120) + 0x3DCC gives 0x4121 (10.0625), and 100.0 (0x42C8) + 1.0 gives exactly 101.0 (0x42CA).
- R5: If the exponents differ by 8 or more, the smaller operand shifts away completely and the larger operand comes back unchanged, for addition and for subtraction.
- R6: When the signs differ, the smaller magnitude is subtracted from the larger one, and the result takes the sign of the larger magnitude. So 0x3F80 + 0xC040 = 0xC000 and 0x4040 + 0xC000 = 0x3F80.
- R7: After a subtraction loses leading bits, the significand shifts left by its leading-zero count and the exponent drops by that same count. So 0x3F81 + 0xBF80 = 0x3C00.
- R8: Two operands of equal magnitude and opposite sign (both nonzero) give 0x0000.
- R9: If one operand is 0x0000, the result is the other operand bit for bit, and 0x0000 + 0x0000 = 0x0000.
- R10: The result does not depend on the order of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| sum_q | output | 16 | Registered sum |

## Verification
The datapath holds no state apart from the output register. Any fault in ordering, alignment or normalisation therefore shows up in the very next `sum_q` word, as a wrong sign, a wrong exponent or wrong fraction bits. The directed cases are chosen so that each fault lands in a different field. A wrong magnitude comparison flips the sign of mixed-sign sums, a shift fault breaks the truncation examples, and a leading-zero fault breaks the deep-cancellation result. A reset fault would leave a nonzero word on `sum_q` during reset.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 7;

  typedef enum logic {
    SIG_ADD = 1'b0,
    SIG_SUB = 1'b1
  } sig_op_e;
endpackage

// File: rtl/fpa_order.sv
module fpa_order
  import fpa_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic             big_sgn,
  output logic [EXP_W-1:0] big_exp,
  output logic [SIG_W-1:0] big_sig,
  output logic [SIG_W-1:0] sml_sig,
  output logic [EXP_W-1:0] exp_gap,
  output sig_op_e          sig_op
);
  logic         a_wins;
  logic [W-1:0] big_w, sml_w;

  // Magnitude order: exponent and fraction compare as one unsigned field
  always_comb begin
    a_wins  = op_a[W-2:0] >= op_b[W-2:0];
    big_w   = a_wins ? op_a : op_b;
    sml_w   = a_wins ? op_b : op_a;
    big_sgn = big_w[W-1];
    big_exp = big_w[W-2:FRAC_W];
    big_sig = {1'b1, big_w[FRAC_W-1:0]};
    sml_sig = {1'b1, sml_w[FRAC_W-1:0]};
    exp_gap = big_w[W-2:FRAC_W] - sml_w[W-2:FRAC_W];
    sig_op  = (op_a[W-1] ^ op_b[W-1]) ? SIG_SUB : SIG_ADD;
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int SIG_W = 8,
  parameter int SH_W  = 8
) (
  input  logic [SIG_W-1:0] sig_in,
  input  logic [SH_W-1:0]  shamt,
  output logic [SIG_W-1:0] sig_out
);
  // Truncating right shift; a gap of SIG_W or more empties the significand
  always_comb begin
    if (shamt >= SH_W'(SIG_W)) sig_out = '0;
    else                       sig_out = sig_in >> shamt;
  end
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
  import fpa_pkg::*;
#(
  parameter int SIG_W = 8
) (
  input  logic [SIG_W-1:0] big_sig,
  input  logic [SIG_W-1:0] sml_sig,
  input  sig_op_e          sig_op,
  output logic [SIG_W:0]   raw
);
  always_comb begin
    if (sig_op == SIG_SUB) raw = {1'b0, big_sig} - {1'b0, sml_sig};
    else                   raw = {1'b0, big_sig} + {1'b0, sml_sig};
  end
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7,
  localparam int SIG_W = FRAC_W + 1,
  localparam int CNT_W = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W:0]    raw,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [EXP_W-1:0]  exp_out,
  output logic [FRAC_W-1:0] frac_out,
  output logic              is_zero
);
  logic [CNT_W-1:0] lz;
  logic [SIG_W-1:0] sig_n;

  // Leading-one search: the highest set bit is found last and wins
  always_comb begin
    lz = CNT_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (raw[i]) lz = CNT_W'(SIG_W - 1 - i);
    end
  end

  always_comb begin
    is_zero = (raw == '0);
    if (raw[SIG_W]) begin
      sig_n   = raw[SIG_W:1];
      exp_out = exp_in + EXP_W'(1);
    end else begin
      sig_n   = raw[SIG_W-1:0] << lz;
      exp_out = exp_in - EXP_W'(lz);
    end
    frac_out = sig_n[FRAC_W-1:0];
  end
endmodule

// File: rtl/fpa_add_top.sv
module fpa_add_top
  import fpa_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic [EXP_W+FRAC_W:0]   sum_q
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;

  logic             big_sgn;
  logic [EXP_W-1:0] big_exp, exp_gap, n_exp;
  logic [SIG_W-1:0] big_sig, sml_sig, sml_al;
  logic [SIG_W:0]   raw;
  logic [FRAC_W-1:0] n_frac;
  logic             n_zero;
  sig_op_e          sig_op;
  logic [W-1:0]     sum_d;

  fpa_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) order_i (
    .op_a(op_a), .op_b(op_b), .big_sgn(big_sgn), .big_exp(big_exp),
    .big_sig(big_sig), .sml_sig(sml_sig), .exp_gap(exp_gap), .sig_op(sig_op)
  );

  fpa_align #(.SIG_W(SIG_W), .SH_W(EXP_W)) align_i (
    .sig_in(sml_sig), .shamt(exp_gap), .sig_out(sml_al)
  );

  fpa_addsub #(.SIG_W(SIG_W)) addsub_i (
    .big_sig(big_sig), .sml_sig(sml_al), .sig_op(sig_op), .raw(raw)
  );

  fpa_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) norm_i (
    .raw(raw), .exp_in(big_exp), .exp_out(n_exp), .frac_out(n_frac),
    .is_zero(n_zero)
  );

  // Next-state: positive zero bypasses the datapath
  always_comb begin
    if (op_a == '0)      sum_d = op_b;
    else if (op_b == '0) sum_d = op_a;
    else if (n_zero)     sum_d = '0;
    else                 sum_d = {big_sgn, n_exp, n_frac};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end
endmodule

// File: rtl/fpa_add_chk.sv
module fpa_add_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] sum_q
);
  logic             past_ok;
  logic [EXP_W-1:0] ea, eb, emax, es;
  logic             same_sgn, a_gt, b_gt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    ea       = op_a[W-2:FRAC_W];
    eb       = op_b[W-2:FRAC_W];
    emax     = (ea > eb) ? ea : eb;
    es       = sum_q[W-2:FRAC_W];
    same_sgn = op_a[W-1] == op_b[W-1];
    a_gt     = op_a[W-2:0] > op_b[W-2:0];
    b_gt     = op_b[W-2:0] > op_a[W-2:0];
  end

  assert_reset_clear_R2: assert property (@(posedge clk)
    !rst_n |-> sum_q == '0);

  assert_zero_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(op_a == '0) |-> sum_q == $past(op_b));

  assert_cancel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(op_a != '0 && op_b != '0 &&
                     op_a == (op_b ^ {1'b1, {(W-1){1'b0}}})) |-> sum_q == '0);

  assert_same_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(same_sgn && ea != '1 && eb != '1)
    |-> sum_q[W-1] == $past(op_a[W-1]) && es >= $past(emax));

  assert_larger_a_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!same_sgn && a_gt) |-> sum_q[W-1] == $past(op_a[W-1]));

  assert_larger_b_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!same_sgn && b_gt) |-> sum_q[W-1] == $past(op_b[W-1]));

  assert_sub_exp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!same_sgn) |-> es <= $past(emax));
endmodule

bind fpa_add_top fpa_add_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_q(sum_q)
);

// File: tb/fpa_add_top_tb_top.sv
`timescale 1ns/1ps
module fpa_add_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [15:0] sum_q;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  fpa_add_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_q(sum_q)
  );

  task automatic check(input string req, input logic [15:0] got,
                       input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // Apply at a falling edge, sample at the next falling edge
  task automatic add_chk(input string req, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] exp);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
    check(req, sum_q, exp);
  endtask

  task automatic t_reset_R2;
    rst_n = 1'b0;
    op_a  = 16'h4040;
    op_b  = 16'h4040;
    repeat (3) @(negedge clk);
    check("R2 reset value", sum_q, 16'h0000);
    rst_n = 1'b1;
    op_a  = 16'h3F80;
    op_b  = 16'h4000;
    #1;
    check("R2 no result before clock", sum_q, 16'h0000);
    @(negedge clk);
    check("R2 one-cycle latency", sum_q, 16'h4040);
  endtask

  task automatic t_basic_R1;
    add_chk("R1 1+2", 16'h3F80, 16'h4000, 16'h4040);
    add_chk("R1 0.5+0.5", 16'h3F00, 16'h3F00, 16'h3F80);
  endtask

  task automatic t_carry_R3;
    add_chk("R3 1+1 carry", 16'h3F80, 16'h3F80, 16'h4000);
    add_chk("R3 -1 + -1", 16'hBF80, 16'hBF80, 16'hC000);
  endtask

  task automatic t_trunc_R4;
    add_chk("R4 10+0.1", 16'h4120, 16'h3DCC, 16'h4121);
    add_chk("R4 100+1", 16'h42C8, 16'h3F80, 16'h42CA);
  endtask

  task automatic t_gap_R5;
    add_chk("R5 gap 10", 16'h4480, 16'h3F80, 16'h4480);
    add_chk("R5 gap 8", 16'h3F80, 16'h4380, 16'h4380);
    add_chk("R5 gap 8 subtract", 16'h4380, 16'hBF80, 16'h4380);
  endtask

  task automatic t_mixed_R6;
    add_chk("R6 1 + -3", 16'h3F80, 16'hC040, 16'hC000);
    add_chk("R6 3 + -2", 16'h4040, 16'hC000, 16'h3F80);
  endtask

  task automatic t_renorm_R7;
    add_chk("R7 deep cancel", 16'h3F81, 16'hBF80, 16'h3C00);
  endtask

  task automatic t_cancel_R8;
    add_chk("R8 3 + -3", 16'h4040, 16'hC040, 16'h0000);
    add_chk("R8 -100 + 100", 16'hC2C8, 16'h42C8, 16'h0000);
  endtask

  task automatic t_zero_R9;
    add_chk("R9 0 + x", 16'h0000, 16'h4121, 16'h4121);
    add_chk("R9 x + 0", 16'hBF80, 16'h0000, 16'hBF80);
    add_chk("R9 0 + 0", 16'h0000, 16'h0000, 16'h0000);
  endtask

  task automatic t_swap_R10;
    add_chk("R10 0.1+10", 16'h3DCC, 16'h4120, 16'h4121);
    add_chk("R10 -2+3", 16'hC000, 16'h4040, 16'h3F80);
    add_chk("R10 -1 + 1.0078125", 16'hBF80, 16'h3F81, 16'h3C00);
  endtask

  initial begin
    #1_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_R2();
    t_basic_R1();
    t_carry_R3();
    t_trunc_R4();
    t_gap_R5();
    t_mixed_R6();
    t_renorm_R7();
    t_cancel_R8();
    t_zero_R9();
    t_swap_R10();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule